// File: doc/BRIEF.md
# Cross-Channel Correction-Bit Parity Engine

This block maintains one shared parity word over the error-correction check bits of the lines at the same relative location in a group of independent memory channels. Only the correction part of each line's code takes part; detection bits never enter the block. The surrounding controller streams the words of one group through the block, one word per beat. A group opens on the first valid beat and closes on the beat marked last. One cycle after the closing beat, the block presents the bitwise XOR of every word in the group.

The block has two modes, chosen on the opening beat of a group. In encode mode the controller streams the correction-bit vectors of the matching lines of N−1 channels. The XOR that comes out is the parity word that is written to the remaining channel. In rebuild mode the controller streams the stored parity word together with freshly computed correction bits of the healthy channels. The XOR that comes out is then the correction-bit vector of the one faulty channel.

In rebuild mode each beat carries a flag that marks its channel as also erroneous at this location. The channel being rebuilt always counts as one erroneous channel. If the count exceeds one, the location cannot be recovered. The block then reports this instead of a result, and the result word is zeroed.

Top module: `xcp_engine`

## Requirements
- R1: While reset is high and on the first cycle after it, `res_valid_o` and `res_unrec_o` are 0 and `res_word_o` is all zeros.
- R2: In encode mode (`mode_i` = 0 on the opening beat), the cycle after the closing beat has `res_valid_o` = 1 and `res_word_o` equal to the XOR of every word accepted in the group.
- R3: The first accepted beat of each group starts a fresh XOR. No word from an earlier group contributes, and a one-beat group returns its own word.
- R4: Cycles with `beat_valid_i` = 0 change nothing: `beat_word_i`, `beat_flag_i`, `beat_last_i` and `mode_i` are ignored on them.
- R5: The mode is taken from `mode_i` on the opening beat only. Later values of `mode_i` within the same group have no effect.
- R6: In rebuild mode (`mode_i` = 1 on the opening beat) with no flagged beat, the result is the XOR of the stored parity and the other channels' correction bits. This equals the missing channel's original bits, whichever channel is missing and in whatever beat order the words arrive.
- R7: In rebuild mode, the erroneous-channel count is one (the rebuilt channel) plus the number of beats with `beat_flag_i` = 1. When it exceeds one, the cycle after the closing beat has `res_unrec_o` = 1, `res_valid_o` = 0 and `res_word_o` = 0.
- R8: In encode mode `beat_flag_i` is ignored, and every group ends with `res_valid_o` = 1.
- R9: `res_valid_o` and `res_unrec_o` are high only in the cycle after a closing beat, and never both at once. `res_word_o` keeps its value on cycles that carry no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | Group mode, sampled on the opening beat: 0 encode, 1 rebuild |
| beat_valid_i | input | 1 | Current beat carries a word |
| beat_last_i | input | 1 | Current beat closes the group |
| beat_flag_i | input | 1 | Channel of this beat is also erroneous at this location (rebuild only) |
| beat_word_i | input | CBITS | Correction-bit vector or stored parity word |
| res_valid_o | output | 1 | One-cycle pulse: result word is valid |
| res_unrec_o | output | 1 | One-cycle pulse: location cannot be recovered |
| res_word_o | output | CBITS | Parity word (encode) or rebuilt correction bits (rebuild) |

## Verification
The bench encodes a parity word over N−1 channels. It then rebuilds every channel in turn from that parity and the others, and compares each result with the original vector. A design that dropped a channel or kept a word from an earlier group would fail here. Idle cycles carrying junk words and junk mode values probe the beat qualification. A design that sampled data without `beat_valid_i`, or re-read `mode_i` during a group, would give a wrong XOR or the wrong outcome. Flagged beats are sent in both modes, and so are one-beat groups and groups that follow each other with no gap. These catch a counter that missed the rebuilt channel, an engine that flagged encode groups, and output pulses that stuck or overlapped.

// File: rtl/xcp_pkg.sv
package xcp_pkg;

    typedef enum logic {
        MODE_ENCODE  = 1'b0,
        MODE_REBUILD = 1'b1
    } xcp_mode_e;

    typedef struct packed {
        logic ok;
        logic unrec;
    } xcp_status_t;

    function automatic int cnt_width(input int chans);
        return $clog2(chans + 1);
    endfunction

endpackage

// File: rtl/xcp_group_ctrl.sv
module xcp_group_ctrl
    import xcp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      beat_valid_i,
    input  logic      beat_last_i,
    input  logic      mode_i,
    output logic      open_o,
    output logic      close_o,
    output xcp_mode_e mode_o
);

    logic      in_grp_q;
    xcp_mode_e mode_q;

    assign open_o  = beat_valid_i && !in_grp_q;
    assign close_o = beat_valid_i && beat_last_i;
    assign mode_o  = open_o ? xcp_mode_e'(mode_i) : mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_grp_q <= 1'b0;
            mode_q   <= MODE_ENCODE;
        end else if (beat_valid_i) begin
            in_grp_q <= !beat_last_i;
            if (open_o) begin
                mode_q <= xcp_mode_e'(mode_i);
            end
        end
    end

    // R5: mode is held for the whole group once it is open
    p_mode_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (in_grp_q && !open_o) |=> (!in_grp_q || $stable(mode_q)));

endmodule

// File: rtl/xcp_xor_accum.sv
module xcp_xor_accum #(
    parameter int CBITS = 64,
    parameter int SYM_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             load_i,
    input  logic [CBITS-1:0] word_i,
    output logic [CBITS-1:0] sum_o
);

    localparam int LANES = CBITS / SYM_W;

    logic [CBITS-1:0] acc_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [SYM_W-1:0] w_l;
        logic [SYM_W-1:0] a_l;
        logic [SYM_W-1:0] n_l;

        assign w_l = word_i[g*SYM_W +: SYM_W];
        assign a_l = acc_q[g*SYM_W +: SYM_W];
        assign n_l = load_i ? w_l : (a_l ^ w_l);
        assign sum_o[g*SYM_W +: SYM_W] = n_l;

        always_ff @(posedge clk) begin
            if (rst) begin
                acc_q[g*SYM_W +: SYM_W] <= '0;
            end else if (en_i) begin
                acc_q[g*SYM_W +: SYM_W] <= n_l;
            end
        end
    end

    // R4: an idle cycle leaves the running XOR untouched
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> $stable(acc_q));

    // R3: an opening beat replaces the running XOR with its own word
    p_fresh_start_r3: assert property (@(posedge clk) disable iff (rst)
        (en_i && load_i) |=> (acc_q == $past(word_i)));

endmodule

// File: rtl/xcp_flag_count.sv
module xcp_flag_count #(
    parameter int CHANNELS = 4,
    parameter int CW       = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_i,
    input  logic          load_i,
    input  logic          flag_i,
    output logic [CW-1:0] cnt_o
);

    localparam logic [CW-1:0] CNT_MAX = CW'(CHANNELS);
    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] base;

    assign base  = load_i ? CNT_ONE : cnt_q;
    assign cnt_o = (flag_i && base != CNT_MAX) ? base + CNT_ONE : base;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CNT_ONE;
        end else if (en_i) begin
            cnt_q <= cnt_o;
        end
    end

    // R7: the count never passes the number of channels
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
        (cnt_q >= CNT_ONE) && (cnt_q <= CNT_MAX));

endmodule

// File: rtl/xcp_engine.sv
module xcp_engine
    import xcp_pkg::*;
#(
    parameter int CHANNELS = 4,
    parameter int CBITS    = 64,
    parameter int SYM_W    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_i,
    input  logic             beat_valid_i,
    input  logic             beat_last_i,
    input  logic             beat_flag_i,
    input  logic [CBITS-1:0] beat_word_i,
    output logic             res_valid_o,
    output logic             res_unrec_o,
    output logic [CBITS-1:0] res_word_o
);

    localparam int CW = cnt_width(CHANNELS);
    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    logic             open_w;
    logic             close_w;
    xcp_mode_e        mode_w;
    logic [CBITS-1:0] sum_w;
    logic [CW-1:0]    cnt_w;
    xcp_status_t      st_d;
    xcp_status_t      st_q;
    logic [CBITS-1:0] word_q;

    xcp_group_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .beat_valid_i (beat_valid_i),
        .beat_last_i  (beat_last_i),
        .mode_i       (mode_i),
        .open_o       (open_w),
        .close_o      (close_w),
        .mode_o       (mode_w)
    );

    xcp_xor_accum #(.CBITS(CBITS), .SYM_W(SYM_W)) u_accum (
        .clk    (clk),
        .rst    (rst),
        .en_i   (beat_valid_i),
        .load_i (open_w),
        .word_i (beat_word_i),
        .sum_o  (sum_w)
    );

    xcp_flag_count #(.CHANNELS(CHANNELS), .CW(CW)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .en_i   (beat_valid_i),
        .load_i (open_w),
        .flag_i (beat_flag_i),
        .cnt_o  (cnt_w)
    );

    always_comb begin
        st_d = '0;
        if (close_w) begin
            if (mode_w == MODE_REBUILD && cnt_w > CNT_ONE) begin
                st_d.unrec = 1'b1;
            end else begin
                st_d.ok = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            word_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_d.unrec) begin
                word_q <= '0;
            end else if (st_d.ok) begin
                word_q <= sum_w;
            end
        end
    end

    assign res_valid_o = st_q.ok;
    assign res_unrec_o = st_q.unrec;
    assign res_word_o  = word_q;

    // R9: the two outcome pulses never coincide
    p_one_outcome_r9: assert property (@(posedge clk) disable iff (rst)
        !(res_valid_o && res_unrec_o));

    // R9: an outcome appears only after a closing beat
    p_after_close_r9: assert property (@(posedge clk) disable iff (rst)
        (res_valid_o || res_unrec_o) |-> $past(beat_valid_i && beat_last_i));

    // R7: an unrecoverable location exposes no result bits
    p_unrec_zero_r7: assert property (@(posedge clk) disable iff (rst)
        res_unrec_o |-> (res_word_o == '0));

    // R8: an encode group always ends with a valid result
    p_encode_ok_r8: assert property (@(posedge clk) disable iff (rst)
        (close_w && mode_w == MODE_ENCODE) |=> res_valid_o);

    // R9: the word holds between results
    p_word_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(st_d.ok || st_d.unrec) |=> $stable(res_word_o));

endmodule

// File: tb/xcp_engine_bench.sv
module xcp_engine_bench;

    localparam int CHANNELS = 4;
    localparam int CBITS    = 64;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             mode_i = 1'b0;
    logic             beat_valid_i = 1'b0;
    logic             beat_last_i = 1'b0;
    logic             beat_flag_i = 1'b0;
    logic [CBITS-1:0] beat_word_i = '0;
    logic             res_valid_o;
    logic             res_unrec_o;
    logic [CBITS-1:0] res_word_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    xcp_engine #(.CHANNELS(CHANNELS), .CBITS(CBITS)) u_xcp_engine (
        .clk          (clk),
        .rst          (rst),
        .mode_i       (mode_i),
        .beat_valid_i (beat_valid_i),
        .beat_last_i  (beat_last_i),
        .beat_flag_i  (beat_flag_i),
        .beat_word_i  (beat_word_i),
        .res_valid_o  (res_valid_o),
        .res_unrec_o  (res_unrec_o),
        .res_word_o   (res_word_o)
    );

    always #10 clk = ~clk;

    // behavioural reference: keeps the group's words in a queue
    logic [CBITS-1:0] grp_q[$];
    bit               m_in_grp = 1'b0;
    bit               m_mode   = 1'b0;
    int               m_flags  = 0;
    logic             exp_v = 1'b0;
    logic             exp_u = 1'b0;
    logic [CBITS-1:0] exp_w = '0;

    always @(posedge clk) begin
        if (rst) begin
            exp_v = 1'b0; exp_u = 1'b0; exp_w = '0;
            m_in_grp = 1'b0; grp_q.delete();
        end else begin
            exp_v = 1'b0; exp_u = 1'b0;
            if (beat_valid_i) begin
                if (!m_in_grp) begin
                    grp_q.delete();
                    m_mode  = mode_i;
                    m_flags = 0;
                end
                grp_q.push_back(beat_word_i);
                if (beat_flag_i) m_flags++;
                m_in_grp = 1'b1;
                if (beat_last_i) begin
                    logic [CBITS-1:0] x;
                    x = '0;
                    foreach (grp_q[i]) x ^= grp_q[i];
                    if (m_mode && (1 + m_flags) > 1) begin
                        exp_u = 1'b1; exp_w = '0;
                    end else begin
                        exp_v = 1'b1; exp_w = x;
                    end
                    m_in_grp = 1'b0;
                end
            end
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            string tag;
            tag = rst ? "R1" : (exp_u ? "R7" : (exp_v ? "R2" : "R9"));
            checks++;
            if (res_valid_o !== exp_v || res_unrec_o !== exp_u || res_word_o !== exp_w) begin
                errors++;
                $display("FAIL %s cycle compare: got v=%b u=%b w=%h exp v=%b u=%b w=%h",
                         tag, res_valid_o, res_unrec_o, res_word_o, exp_v, exp_u, exp_w);
            end
        end
    end

    task automatic chk(input string tag, input logic [CBITS-1:0] got, input logic [CBITS-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic send(input logic [CBITS-1:0] w, input logic m, input logic f, input logic l);
        beat_valid_i = 1'b1; beat_word_i = w; mode_i = m; beat_flag_i = f; beat_last_i = l;
        @(negedge clk);
        beat_valid_i = 1'b0; beat_last_i = 1'b0; beat_flag_i = 1'b0;
    endtask

    task automatic idle_junk(input int n);
        for (int i = 0; i < n; i++) begin
            beat_valid_i = 1'b0;
            beat_word_i  = {$urandom, $urandom};
            mode_i       = 1'($urandom);
            beat_flag_i  = 1'b1;
            beat_last_i  = 1'b1;
            @(negedge clk);
        end
        beat_flag_i = 1'b0; beat_last_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        finish_run();
    end

    logic [CBITS-1:0] orig [CHANNELS-1];
    logic [CBITS-1:0] par;

    initial begin
        logic [CBITS-1:0] x;
        @(negedge clk);
        @(negedge clk);
        chk("R1 valid in reset", {63'd0, res_valid_o}, '0);
        chk("R1 word in reset", res_word_o, '0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", {62'd0, res_valid_o, res_unrec_o}, '0);

        // R2: encode parity over N-1 channels
        x = '0;
        for (int c = 0; c < CHANNELS - 1; c++) begin
            orig[c] = {$urandom, $urandom};
            x ^= orig[c];
        end
        for (int c = 0; c < CHANNELS - 1; c++)
            send(orig[c], (c == 0) ? 1'b0 : 1'b1, 1'b0, c == CHANNELS - 2);
        chk("R2 encode valid", {63'd0, res_valid_o}, 64'd1);
        chk("R2 encode parity", res_word_o, x);
        par = res_word_o;
        idle_junk(2);

        // R6: rebuild each missing channel, parity first for even, last for odd
        for (int m = 0; m < CHANNELS - 1; m++) begin
            int sent;
            sent = 0;
            if (m % 2 == 0) begin send(par, 1'b1, 1'b0, 1'b0); sent++; end
            for (int c = 0; c < CHANNELS - 1; c++) begin
                if (c != m) begin
                    sent++;
                    send(orig[c], (sent == 1) ? 1'b1 : 1'b0, 1'b0,
                         (m % 2 == 0) && (sent == CHANNELS - 1));
                end
            end
            if (m % 2 == 1) send(par, 1'b0, 1'b0, 1'b1);
            chk("R6 rebuild valid", {63'd0, res_valid_o}, 64'd1);
            chk("R6 rebuilt equals original", res_word_o, orig[m]);
            idle_junk(1);
        end

        // R4: gaps with junk between beats
        send(orig[0], 1'b0, 1'b0, 1'b0);
        idle_junk(3);
        send(orig[1], 1'b0, 1'b0, 1'b0);
        idle_junk(2);
        send(orig[2], 1'b0, 1'b0, 1'b1);
        chk("R4 gaps ignored", res_word_o, orig[0] ^ orig[1] ^ orig[2]);

        // R3: one-beat group right after, no gap
        send(64'hA5A5_0F0F_1234_5678, 1'b0, 1'b0, 1'b1);
        chk("R3 single beat fresh", res_word_o, 64'hA5A5_0F0F_1234_5678);
        send(64'h0000_0000_0000_00FF, 1'b1, 1'b0, 1'b1);
        chk("R3 back-to-back fresh", res_word_o, 64'h0000_0000_0000_00FF);

        // R7: second erroneous channel in rebuild
        send(par, 1'b1, 1'b0, 1'b0);
        send(orig[1], 1'b1, 1'b1, 1'b0);
        send(orig[2], 1'b1, 1'b0, 1'b1);
        chk("R7 unrecoverable flagged", {63'd0, res_unrec_o}, 64'd1);
        chk("R7 no valid", {63'd0, res_valid_o}, '0);
        chk("R7 word zeroed", res_word_o, '0);
        idle_junk(1);
        chk("R9 pulse ends", {62'd0, res_valid_o, res_unrec_o}, '0);

        // R8: flags ignored in encode
        send(orig[0], 1'b0, 1'b1, 1'b0);
        send(orig[1], 1'b0, 1'b1, 1'b1);
        chk("R8 encode flags ignored", {63'd0, res_valid_o}, 64'd1);
        chk("R8 encode word", res_word_o, orig[0] ^ orig[1]);

        // R5: mode flips mid-group are ignored
        send(orig[0], 1'b0, 1'b1, 1'b0);
        send(orig[1], 1'b1, 1'b1, 1'b1);
        chk("R5 encode kept", {63'd0, res_valid_o}, 64'd1);
        send(par, 1'b1, 1'b0, 1'b0);
        send(orig[0], 1'b0, 1'b1, 1'b1);
        chk("R5 rebuild kept", {63'd0, res_unrec_o}, 64'd1);

        idle_junk(4);
        chk("R9 word held idle", res_word_o, '0);
        finish_run();
    end

endmodule